// File: doc/BRIEF.md
# Buffer-Paced DMA Request Controller

This block decides when a graphics accelerator raises its request line toward a system DMA engine. The DMA engine fills a local input buffer, and an internal consumer drains it. Each granted request moves one operand, which is eight 16-bit items or 16 bytes. The block counts the bytes accepted against a programmed total. It also keeps an occupancy count of the buffer, which the DMA side raises and the consumer drain lowers.

The block has two pacing modes. In single-operand mode, a burst starts only when the buffer has room for a whole chunk. A chunk is one buffer capacity, or the remaining bytes if fewer are left. When a chunk ends and room is still there, the next burst follows without a gap. Otherwise the request line stays low until enough has drained. In continuous-operand mode, the request stays up from start to the last byte and ignores the buffer level. The configuration is therefore checked at start: on the small buffer the line width must be 32 or 64 pixels.

Top module: `dmaReqCtrl`

## Requirements
- R1: Each accepted operand counts as 16 bytes. The transfer ends when the accepted bytes equal the programmed total.
- R2: `largeBuf`=0 selects a 128-byte buffer and `largeBuf`=1 selects a 960-byte buffer. Both are latched at a valid start. `bufFull` is high while occupancy equals the selected capacity.
- R3: In single-operand mode, `dmaReq` rises only when free space is at least min(capacity, remaining bytes). It falls on the clock after the accept that completes the chunk.
- R4: In single-operand mode, if room for the next chunk exists on the cycle a chunk completes, `dmaReq` stays high with no gap. Otherwise it stays low until a drain frees the room.
- R5: In continuous-operand mode, `dmaReq` is high from the cycle after a valid start until the accept that reaches the total, whatever `bufFull` shows.
- R6: A start with `contMode`=1, `largeBuf`=0 and `lineWidth` other than 32 or 64 sets `cfgErr` and raises no request.
- R7: A start whose total is zero or not a multiple of 16 sets `cfgErr` and raises no request. A valid start clears `cfgErr`.
- R8: `xferDone` is high for exactly one cycle after the final accept, and `dmaReq` is low in that cycle. A `startPulse` while a transfer is active is ignored.
- R9: Occupancy rises by 16 per accept, falls by 16 per drain, and saturates at the capacity. A drain while occupancy is zero is ignored.
- R10: `opAccept` while `dmaReq` is low changes no count.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start a transfer with the current configuration |
| totalBytes | input | 16 | Programmed transfer size in bytes |
| contMode | input | 1 | 1 = continuous-operand, 0 = single-operand |
| largeBuf | input | 1 | Buffer capacity select (0 = 128 B, 1 = 960 B) |
| lineWidth | input | 12 | Horizontal pixels per line |
| opAccept | input | 1 | DMA side accepted one operand |
| drainPulse | input | 1 | Consumer removed one operand |
| dmaReq | output | 1 | DMA request line |
| bufFull | output | 1 | Buffer occupancy at capacity |
| xferDone | output | 1 | One-cycle end-of-transfer pulse |
| cfgErr | output | 1 | Last start was rejected |

## Verification
The bench targets several corner cases, each tied to a specific failure.
- A total of 384 bytes on the small buffer must take three separate fills, each gated by a full drain. A design that ignored occupancy would request straight through.
- Drains that arrive during a chunk's last accept decide whether the next burst follows at once. A design that evaluated room on stale counts would show a spurious gap or an early request.
- A 48-byte total is shorter than one capacity. A design that waited for a whole buffer of room here would stall, and one that counted chunks against a shrinking remainder would end bursts early.
- Continuous runs overfill a full buffer. Occupancy must saturate and the request must stay high.
- Drains on an empty buffer, accepts while the request is low, and starts while a transfer is active must all leave the counts unchanged.

// File: rtl/dmaReqPkg.sv
package dmaReqPkg;
  typedef struct packed {
    logic acceptEn;
    logic drainReq;
    logic loadCfg;
  } ctrlStrb_t;
endpackage

// File: rtl/dmaReqData.sv
module dmaReqData
  import dmaReqPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int OPER_BYTES = 16,
  parameter int SMALL_CAP  = 128,
  parameter int LARGE_CAP  = 960
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] totalBytes,
  input  logic             largeBuf,
  output logic             roomNext,
  output logic             chunkEnd,
  output logic             xferEnd,
  output logic             bufFull
);
  localparam logic [CNT_W-1:0] OPB  = CNT_W'(OPER_BYTES);
  localparam logic [CNT_W-1:0] CAPS = CNT_W'(SMALL_CAP);
  localparam logic [CNT_W-1:0] CAPL = CNT_W'(LARGE_CAP);

  logic             largeReg;
  logic [CNT_W-1:0] totReg, accCnt, chunkCnt, occ;
  logic [CNT_W-1:0] capNow, capNext, totNext, accNext, chunkNext, occNext;
  logic [CNT_W-1:0] inc, dec, freeNext, remNext, lenNext;
  logic [CNT_W:0]   occSum;

  assign capNow  = largeReg ? CAPL : CAPS;
  assign inc     = strb.acceptEn ? OPB : '0;
  assign dec     = (strb.drainReq && occ != '0) ? OPB : '0;
  assign xferEnd  = strb.acceptEn && (accCnt + OPB == totReg);
  assign chunkEnd = strb.acceptEn && ((chunkCnt + OPB == capNow) || (accCnt + OPB == totReg));

  always_comb begin
    capNext   = strb.loadCfg ? (largeBuf ? CAPL : CAPS) : capNow;
    totNext   = strb.loadCfg ? totalBytes : totReg;
    accNext   = strb.loadCfg ? '0 : accCnt + inc;
    chunkNext = (strb.loadCfg || chunkEnd) ? '0 : chunkCnt + inc;
    occSum    = {1'b0, occ} + {1'b0, inc} - {1'b0, dec};
    occNext   = (occSum > {1'b0, capNext}) ? capNext : occSum[CNT_W-1:0];
    freeNext  = capNext - occNext;
    remNext   = totNext - accNext;
    lenNext   = (capNext < remNext) ? capNext : remNext;
    roomNext  = freeNext >= lenNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      largeReg <= 1'b0;
      totReg   <= '0;
      accCnt   <= '0;
      chunkCnt <= '0;
      occ      <= '0;
    end else begin
      largeReg <= strb.loadCfg ? largeBuf : largeReg;
      totReg   <= totNext;
      accCnt   <= accNext;
      chunkCnt <= chunkNext;
      occ      <= occNext;
    end
  end

  assign bufFull = (occ == capNow);

  AST_OCC_SAT: assert property (@(posedge clk) disable iff (!rstN) occ <= capNow); // R9
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rstN) accCnt <= totReg); // R1
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rstN) chunkCnt < capNow); // R3
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0 && !strb.acceptEn) |=> occ == '0); // R9
endmodule

// File: rtl/dmaReqCtrl_fsm.sv
module dmaReqCtrl_fsm
  import dmaReqPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LINE_W     = 12,
  parameter int OPER_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic              contMode,
  input  logic              largeBuf,
  input  logic [LINE_W-1:0] lineWidth,
  input  logic              opAccept,
  input  logic              drainPulse,
  input  logic              roomNext,
  input  logic              chunkEnd,
  input  logic              xferEnd,
  output ctrlStrb_t         strb,
  output logic              dmaReq,
  output logic              xferDone,
  output logic              cfgErr
);
  localparam logic [CNT_W-1:0] OPB = CNT_W'(OPER_BYTES);

  logic active, inBurst, contReg, doneQ, errQ;
  logic widthOk, sizeOk, cfgGood, tryStart;

  assign widthOk  = largeBuf || !contMode ||
                    lineWidth == LINE_W'(32) || lineWidth == LINE_W'(64);
  assign sizeOk   = (totalBytes != '0) && ((totalBytes % OPB) == '0);
  assign cfgGood  = widthOk && sizeOk;
  assign tryStart = startPulse && !active;

  always_comb begin
    strb.acceptEn = opAccept && inBurst;
    strb.drainReq = drainPulse;
    strb.loadCfg  = tryStart && cfgGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      inBurst <= 1'b0;
      contReg <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (tryStart) begin
        if (cfgGood) begin
          active  <= 1'b1;
          errQ    <= 1'b0;
          contReg <= contMode;
          inBurst <= contMode ? 1'b1 : roomNext;
        end else begin
          errQ <= 1'b1;
        end
      end else if (active) begin
        if (xferEnd) begin
          active  <= 1'b0;
          inBurst <= 1'b0;
          doneQ   <= 1'b1;
        end else if (contReg) begin
          inBurst <= 1'b1;
        end else begin
          inBurst <= (inBurst && !chunkEnd) || roomNext;
        end
      end
    end
  end

  assign dmaReq   = inBurst;
  assign xferDone = doneQ;
  assign cfgErr   = errQ;

  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rstN) inBurst |-> active); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN) doneQ |=> !doneQ); // R8
  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && contReg && !xferEnd) |=> inBurst); // R5
  AST_ERR_NOREQ: assert property (@(posedge clk) disable iff (!rstN) errQ |-> !inBurst); // R6
  AST_END_DROP: assert property (@(posedge clk) disable iff (!rstN) xferEnd |=> !inBurst && doneQ); // R8
endmodule

// File: rtl/dmaReqCtrl.sv
module dmaReqCtrl
  import dmaReqPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LINE_W     = 12,
  parameter int OPER_BYTES = 16,
  parameter int SMALL_CAP  = 128,
  parameter int LARGE_CAP  = 960
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic              contMode,
  input  logic              largeBuf,
  input  logic [LINE_W-1:0] lineWidth,
  input  logic              opAccept,
  input  logic              drainPulse,
  output logic              dmaReq,
  output logic              bufFull,
  output logic              xferDone,
  output logic              cfgErr
);
  ctrlStrb_t strb;
  logic roomNext, chunkEnd, xferEnd;

  dmaReqCtrl_fsm #(.CNT_W(CNT_W), .LINE_W(LINE_W), .OPER_BYTES(OPER_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .totalBytes(totalBytes),
    .contMode(contMode), .largeBuf(largeBuf), .lineWidth(lineWidth),
    .opAccept(opAccept), .drainPulse(drainPulse), .roomNext(roomNext),
    .chunkEnd(chunkEnd), .xferEnd(xferEnd), .strb(strb), .dmaReq(dmaReq),
    .xferDone(xferDone), .cfgErr(cfgErr)
  );

  dmaReqData #(.CNT_W(CNT_W), .OPER_BYTES(OPER_BYTES), .SMALL_CAP(SMALL_CAP),
               .LARGE_CAP(LARGE_CAP)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .totalBytes(totalBytes),
    .largeBuf(largeBuf), .roomNext(roomNext), .chunkEnd(chunkEnd),
    .xferEnd(xferEnd), .bufFull(bufFull)
  );
endmodule

// File: tb/sim_dmaReqCtrl.sv
`timescale 1ns/1ps
module sim_dmaReqCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, contMode = 1'b0, largeBuf = 1'b0;
  logic opAccept = 1'b0, drainPulse = 1'b0;
  logic [15:0] totalBytes = '0;
  logic [11:0] lineWidth = '0;
  logic dmaReq, bufFull, xferDone, cfgErr;
  int vecs = 0, errs = 0, cyc = 0, doneSeen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmaReqCtrl u0 (.clk(clk), .rstN(rstN), .startPulse(startPulse), .totalBytes(totalBytes),
    .contMode(contMode), .largeBuf(largeBuf), .lineWidth(lineWidth), .opAccept(opAccept),
    .drainPulse(drainPulse), .dmaReq(dmaReq), .bufFull(bufFull), .xferDone(xferDone),
    .cfgErr(cfgErr));

  // Behavioural reference: byte totals as integers
  int mOcc = 0, mCap = 128, mTot = 0, mAcc = 0, mChunk = 0;
  bit mActive = 0, mReq = 0, mDone = 0, mErr = 0, mCont = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mOcc = 0; mCap = 128; mTot = 0; mAcc = 0; mChunk = 0;
      mActive = 0; mReq = 0; mDone = 0; mErr = 0; mCont = 0;
    end else begin
      bit took, drained, started, ended, good;
      int need;
      took = opAccept && mReq;             // R10: ignored when request is low
      drained = drainPulse && mOcc > 0;    // R9: drain on empty ignored
      started = 0; ended = 0;
      mDone = 0;
      if (startPulse && !mActive) begin    // R8: start while active ignored
        good = totalBytes != 0 && totalBytes % 16 == 0;                    // R7
        if (contMode && !largeBuf && lineWidth != 32 && lineWidth != 64)  // R6
          good = 0;
        if (good) begin
          started = 1; mActive = 1; mErr = 0; mCont = contMode;
          mCap = largeBuf ? 960 : 128; mTot = totalBytes; mAcc = 0; mChunk = 0;
        end else mErr = 1;
      end
      mOcc = mOcc + (took ? 16 : 0) - (drained ? 16 : 0);
      if (mOcc > mCap) mOcc = mCap;
      if (took) begin mAcc += 16; mChunk += 16; end
      if (took && mAcc == mTot) begin
        mActive = 0; mReq = 0; mDone = 1; mChunk = 0;
      end else if (mActive) begin
        if (took && mChunk == mCap) begin ended = 1; mChunk = 0; end
        need = (mTot - mAcc < mCap) ? mTot - mAcc : mCap;
        if (mCont) mReq = 1;
        else if (mReq && !ended && !started) mReq = 1;
        else mReq = (mCap - mOcc) >= need;
      end
    end
  end

  task automatic cmp(input bit act, input bit exp, input string what);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      cmp(dmaReq, mReq, "dmaReq R3 R4 R5 R6 R10");
      cmp(bufFull, mOcc == mCap, "bufFull R2 R9");
      cmp(xferDone, mDone, "xferDone R1 R8");
      cmp(cfgErr, mErr, "cfgErr R6 R7");
      if (xferDone) doneSeen++;
    end
  end

  task automatic start(input int tot, input bit cm, input bit lb, input int w);
    @(negedge clk);
    totalBytes = 16'(tot); contMode = cm; largeBuf = lb; lineWidth = 12'(w);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // accPat: 0 never, 1 always, 2 two of three; drainPat: 0 never, 1 always, 2 every other
  task automatic run(input int n, input int accPat, input int drainPat, input bit pokeStart);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opAccept = (accPat == 1) || (accPat == 2 && i % 3 != 0);
      drainPulse = (drainPat == 1) || (drainPat == 2 && i % 2 == 0);
      startPulse = pokeStart && (i % 17 == 5);
    end
    @(negedge clk);
    opAccept = 1'b0; drainPulse = 1'b0; startPulse = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R11: reset state
        vecs++;
        if ({dmaReq, bufFull, xferDone, cfgErr} !== 4'b0) begin
          errs++;
          $display("FAIL R11 reset outputs actual %b expected 0000",
                   {dmaReq, bufFull, xferDone, cfgErr});
        end
        rstN = 1'b1;
        run(4, 1, 1, 0);                  // R10 R9: accepts and drains while idle
        start(100, 0, 0, 64);             // R7: not a multiple of 16
        run(4, 1, 0, 0);
        start(0, 0, 0, 64);               // R7: zero total
        start(256, 1, 0, 48);             // R6: illegal width on small buffer
        run(4, 1, 0, 0);
        start(384, 0, 0, 64);             // R3 R4: three fills of 128 bytes
        run(30, 1, 0, 1);                 // R8: pokes while active
        run(80, 2, 1, 1);
        run(10, 1, 1, 0);
        start(384, 1, 0, 64);             // R5: continuous, overfills a full buffer
        run(40, 1, 0, 0);
        run(40, 0, 1, 0);                 // R9: drain past empty
        start(48, 0, 0, 32);              // R3: total below capacity
        run(10, 1, 0, 0);
        run(10, 0, 1, 0);
        start(2000, 0, 1, 100);           // R2: large buffer, back-to-back with drains
        run(300, 2, 1, 1);
        start(1920, 1, 1, 100);           // R6: large buffer accepts any width
        run(200, 2, 2, 0);
        run(150, 0, 1, 0);
        start(64, 0, 0, 64);              // R4: drain concurrent with chunk end
        run(20, 1, 1, 0);
        vecs++;
        if (doneSeen < 6) begin
          errs++;
          $display("FAIL R1 R8 transfers completed actual %0d expected at least 6", doneSeen);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual cycle %0d expected completion", cyc);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule